// File: doc/BRIEF.md
# Hot-Plug Slot Control Register

This block holds the 16-bit control word of a hot-plug expansion slot and drives the slot's physical outputs from it. Software writes the whole word through a one-cycle write strobe and reads it back combinationally. The outputs are a slot power enable, a one-cycle pulse that flips an electromechanical latch, and two LED drives: one for slot power and one for attention. Each LED can be held on or off, or made to blink at 1.5 Hz.

The blink rate comes from a divider that is sized from the system clock frequency parameter. Both LEDs share one blink phase, so they blink together. Every accepted write raises a one-cycle event pulse for a neighbouring sideband serial-pin block. A notification-enable bit for link-state changes is also stored and brought out.

There are two resets. The power-on reset is asynchronous and active low, and it clears everything. The warm reset is synchronous and active low. It restores the indicator fields and keeps the two sticky bits, slot power and link notification enable.

Top module: `hp_slot_ctrl`

## Requirements
- R1: After power-on reset, rd_data reads 0x07C0, slot_pwr_en is 0, link_notify_en is 0, lock_state is 0 and both LED outputs are 0.
- R2: Bits 15:13 and 5:0 always read as 0. Writing 1s to them has no effect.
- R3: Writing a word with bit 11 set makes lock_toggle high for exactly the one cycle after the write edge. A write with bit 11 clear gives no pulse. Bit 11 always reads 0.
- R4: lock_state inverts once, in the cycle after each lock_toggle pulse. Power-on reset clears it and warm reset leaves it unchanged.
- R5: Bit 10 stores slot power and reads back as written. A value of 0 means powered, so slot_pwr_en = 1, and a value of 1 means unpowered.
- R6: Bit 12 stores the link-change notification enable, reads back as written and drives link_notify_en.
- R7: Warm reset sets bits 9:8 and 7:6 to 11 and leaves bits 12 and 10 unchanged, and a write presented during warm reset is ignored. Power-on reset returns bit 12 to 0 and bit 10 to 1.
- R8: The power LED field is bits 9:8 and the attention LED field is bits 7:6. Code 01 drives the LED steadily high, code 11 steadily low, and code 10 makes it follow the blink phase.
- R9: The blink phase is low after either reset and inverts every round(CLK_HZ/3) clock edges. Both LEDs show the same phase at all times.
- R10: Writing the code 00 to an indicator field stores 00, and 00 reads back. The LED keeps its previous on, off or blink behaviour.
- R11: Every write accepted outside warm reset makes ind_event high for exactly the one cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| warm_rst_n | input | 1 | Synchronous warm reset, active low; keeps sticky bits |
| wr_en | input | 1 | Write strobe; wr_data is stored at this edge |
| wr_data | input | 16 | Write word |
| rd_data | output | 16 | Current register contents |
| link_notify_en | output | 1 | Link-state-change notification enable |
| slot_pwr_en | output | 1 | Slot power enable, high when powered |
| lock_toggle | output | 1 | One-cycle pulse that flips the latch |
| lock_state | output | 1 | Tracked latch state |
| pwr_led | output | 1 | Power LED drive |
| attn_led | output | 1 | Attention LED drive |
| ind_event | output | 1 | One-cycle pulse after each accepted write |

## Verification
The assertions assume that por_n is the only asynchronous input and that wr_en, wr_data and warm_rst_n change only between clock edges. They also assume that a write seen together with an active warm reset is meant to be dropped. The stimulus drives every input on the falling clock edge and holds each reset across at least one rising edge. It deliberately overlaps one write with a warm reset to exercise that rule. The clock parameter is set to 300 Hz so that a full blink period fits in a few hundred cycles. The blink phase is then predicted edge by edge from the count of edges since reset.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;
    localparam int REG_W    = 16;
    localparam int POS_LINK = 12;
    localparam int POS_LOCK = 11;
    localparam int POS_PWR  = 10;
    localparam int POS_PIND = 8;
    localparam int POS_AIND = 6;
    localparam int N_IND    = 2;

    localparam logic [1:0] CODE_RSVD  = 2'b00;
    localparam logic [1:0] CODE_ON    = 2'b01;
    localparam logic [1:0] CODE_BLINK = 2'b10;
    localparam logic [1:0] CODE_OFF   = 2'b11;

    typedef enum logic [1:0] {
        LED_OFF   = 2'd0,
        LED_ON    = 2'd1,
        LED_BLINK = 2'd2
    } led_mode_e;
endpackage

// File: rtl/hp_blink_gen.sv
module hp_blink_gen #(
    parameter int CLK_HZ = 100_000_000
) (
    input  logic clk,
    input  logic por_n,
    input  logic warm_rst_n,
    output logic phase
);
    localparam int HALF = (CLK_HZ + 1) / 3;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ph;
    } blink_t;

    blink_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!warm_rst_n) begin
            st_d.cnt = '0;
            st_d.ph  = 1'b0;
        end else if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
            st_d.ph  = ~st_q.ph;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign phase = st_q.ph;

    // The phase may only move after a full half period.
    AST_BLINK_HOLD: assert property (@(posedge clk) disable iff (!por_n)
        (warm_rst_n && st_q.cnt != LAST) |=> $stable(st_q.ph)) else $error("blink step"); // R9
    AST_WARM_PHASE: assert property (@(posedge clk) disable iff (!por_n)
        !warm_rst_n |=> !phase) else $error("blink warm"); // R9
endmodule

// File: rtl/hp_ind_drive.sv
module hp_ind_drive
    import hp_slot_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       warm_rst_n,
    input  logic       wr_en,
    input  logic [1:0] code,
    input  logic       blink_phase,
    output logic       led
);
    led_mode_e mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (!warm_rst_n) begin
            mode_d = LED_OFF;
        end else if (wr_en) begin
            case (code)
                CODE_ON:    mode_d = LED_ON;
                CODE_BLINK: mode_d = LED_BLINK;
                CODE_OFF:   mode_d = LED_OFF;
                default:    mode_d = mode_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) mode_q <= LED_OFF;
        else        mode_q <= mode_d;
    end

    always_comb begin
        case (mode_q)
            LED_ON:    led = 1'b1;
            LED_BLINK: led = blink_phase;
            default:   led = 1'b0;
        endcase
    end

    AST_RSVD_HOLD: assert property (@(posedge clk) disable iff (!por_n)
        (warm_rst_n && wr_en && code == CODE_RSVD) |=> mode_q == $past(mode_q)) else $error("rsvd code"); // R10
    AST_ON_LIT: assert property (@(posedge clk) disable iff (!por_n)
        (warm_rst_n && wr_en && code == CODE_ON) |=> led) else $error("on code"); // R8
    AST_OFF_DARK: assert property (@(posedge clk) disable iff (!por_n)
        (warm_rst_n && wr_en && code == CODE_OFF) |=> !led) else $error("off code"); // R8
endmodule

// File: rtl/hp_slot_regs.sv
module hp_slot_regs
    import hp_slot_pkg::*;
(
    input  logic             clk,
    input  logic             por_n,
    input  logic             warm_rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             link_en,
    output logic             pwr_off,
    output logic             lock_pulse,
    output logic             lock_state,
    output logic             evt
);
    typedef struct packed {
        logic       link_en;
        logic       pwr_off;
        logic [1:0] pind;
        logic [1:0] aind;
        logic       lock_pulse;
        logic       lock_state;
        logic       evt;
    } regs_t;

    localparam regs_t RST = '{
        link_en: 1'b0, pwr_off: 1'b1, pind: CODE_OFF, aind: CODE_OFF,
        lock_pulse: 1'b0, lock_state: 1'b0, evt: 1'b0
    };

    regs_t r_d, r_q;

    always_comb begin
        r_d            = r_q;
        r_d.lock_pulse = 1'b0;
        r_d.evt        = 1'b0;
        if (r_q.lock_pulse) r_d.lock_state = ~r_q.lock_state;
        if (!warm_rst_n) begin
            r_d.pind = CODE_OFF;
            r_d.aind = CODE_OFF;
        end else if (wr_en) begin
            r_d.link_en    = wr_data[POS_LINK];
            r_d.pwr_off    = wr_data[POS_PWR];
            r_d.pind       = wr_data[POS_PIND +: 2];
            r_d.aind       = wr_data[POS_AIND +: 2];
            r_d.lock_pulse = wr_data[POS_LOCK];
            r_d.evt        = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) r_q <= RST;
        else        r_q <= r_d;
    end

    always_comb begin
        rd_data                  = '0;
        rd_data[POS_LINK]        = r_q.link_en;
        rd_data[POS_PWR]         = r_q.pwr_off;
        rd_data[POS_PIND +: 2]   = r_q.pind;
        rd_data[POS_AIND +: 2]   = r_q.aind;
    end

    assign link_en    = r_q.link_en;
    assign pwr_off    = r_q.pwr_off;
    assign lock_pulse = r_q.lock_pulse;
    assign lock_state = r_q.lock_state;
    assign evt        = r_q.evt;

    AST_LOCK_FIRE: assert property (@(posedge clk) disable iff (!por_n)
        (warm_rst_n && wr_en && wr_data[POS_LOCK]) |=> lock_pulse) else $error("lock fire"); // R3
    AST_LOCK_IDLE: assert property (@(posedge clk) disable iff (!por_n)
        !(warm_rst_n && wr_en && wr_data[POS_LOCK]) |=> !lock_pulse) else $error("lock idle"); // R3
    AST_LOCK_FLIP: assert property (@(posedge clk) disable iff (!por_n)
        lock_pulse |=> lock_state != $past(lock_state)) else $error("lock flip"); // R4
    AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (!por_n)
        !wr_en |=> ($stable(pwr_off) && $stable(link_en))) else $error("sticky"); // R7
    AST_WARM_IND: assert property (@(posedge clk) disable iff (!por_n)
        !warm_rst_n |=> (rd_data[POS_PIND +: 2] == CODE_OFF && rd_data[POS_AIND +: 2] == CODE_OFF)) else $error("warm ind"); // R7
    AST_EVT_PULSE: assert property (@(posedge clk) disable iff (!por_n)
        (warm_rst_n && wr_en) |=> evt) else $error("event"); // R11
    AST_EVT_QUIET: assert property (@(posedge clk) disable iff (!por_n)
        !(warm_rst_n && wr_en) |=> !evt) else $error("event quiet"); // R11
endmodule

// File: rtl/hp_slot_ctrl.sv
module hp_slot_ctrl
    import hp_slot_pkg::*;
#(
    parameter int CLK_HZ = 100_000_000
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             warm_rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             link_notify_en,
    output logic             slot_pwr_en,
    output logic             lock_toggle,
    output logic             lock_state,
    output logic             pwr_led,
    output logic             attn_led,
    output logic             ind_event
);
    logic             pwr_off;
    logic             phase;
    logic [N_IND-1:0] led_w;

    hp_slot_regs u_regs (
        .clk        (clk),
        .por_n      (por_n),
        .warm_rst_n (warm_rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .link_en    (link_notify_en),
        .pwr_off    (pwr_off),
        .lock_pulse (lock_toggle),
        .lock_state (lock_state),
        .evt        (ind_event)
    );

    hp_blink_gen #(.CLK_HZ(CLK_HZ)) u_blink (
        .clk        (clk),
        .por_n      (por_n),
        .warm_rst_n (warm_rst_n),
        .phase      (phase)
    );

    for (genvar g = 0; g < N_IND; g++) begin : g_ind
        localparam int LSB = (g == 0) ? POS_PIND : POS_AIND;
        hp_ind_drive u_drv (
            .clk         (clk),
            .por_n       (por_n),
            .warm_rst_n  (warm_rst_n),
            .wr_en       (wr_en),
            .code        (wr_data[LSB +: 2]),
            .blink_phase (phase),
            .led         (led_w[g])
        );
    end

    assign slot_pwr_en = ~pwr_off;
    assign pwr_led     = led_w[0];
    assign attn_led    = led_w[1];

    AST_PWR_FOLLOW: assert property (@(posedge clk) disable iff (!por_n)
        (warm_rst_n && wr_en) |=> slot_pwr_en == !$past(wr_data[POS_PWR])) else $error("power"); // R5
    AST_RSVD_READ: assert property (@(posedge clk) disable iff (!por_n)
        (rd_data[15:13] == 3'b000 && rd_data[POS_LOCK] == 1'b0 && rd_data[5:0] == 6'b0)) else $error("reserved read"); // R2
endmodule

// File: tb/tb_hp_slot_ctrl.sv
module tb_hp_slot_ctrl;
    localparam int CLK_HZ = 300;
    localparam int HALF   = (CLK_HZ + 1) / 3;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        warm_rst_n = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        link_notify_en, slot_pwr_en, lock_toggle, lock_state;
    logic        pwr_led, attn_led, ind_event;

    hp_slot_ctrl #(.CLK_HZ(CLK_HZ)) dut (
        .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .link_notify_en(link_notify_en),
        .slot_pwr_en(slot_pwr_en), .lock_toggle(lock_toggle), .lock_state(lock_state),
        .pwr_led(pwr_led), .attn_led(attn_led), .ind_event(ind_event)
    );

    always #5 clk = ~clk;

    typedef enum {S_RD, S_PWR, S_LOCKP, S_LOCKS, S_PLED, S_ALED, S_EVT, S_LINK} sel_e;
    typedef struct {
        sel_e        sel;
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t sb[$];
    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;

    function automatic logic [15:0] pick(sel_e s);
        case (s)
            S_RD:    return rd_data;
            S_PWR:   return {15'b0, slot_pwr_en};
            S_LOCKP: return {15'b0, lock_toggle};
            S_LOCKS: return {15'b0, lock_state};
            S_PLED:  return {15'b0, pwr_led};
            S_ALED:  return {15'b0, attn_led};
            S_EVT:   return {15'b0, ind_event};
            default: return {15'b0, link_notify_en};
        endcase
    endfunction

    task automatic chk(sel_e s, logic [15:0] e, string t);
        item_t it;
        it.sel = s; it.exp = e; it.tag = t;
        sb.push_back(it);
    endtask

    // Monitor: compares queued expectations one time unit after each falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0) begin
                item_t it;
                logic [15:0] act;
                it  = sb.pop_front();
                act = pick(it.sel);
                checks++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s sel=%s actual=%h expected=%h", it.tag, it.sel.name(), act, it.exp);
                end
            end
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [15:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic warm_wr(logic [15:0] v);
        @(negedge clk);
        warm_rst_n = 1'b0; wr_en = 1'b1; wr_data = v;
        @(negedge clk);
        warm_rst_n = 1'b1; wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic por();
        @(negedge clk);
        por_n = 1'b0;
        @(negedge clk);
        por_n = 1'b1;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        idle(2);
        por_n = 1'b1;
        chk(S_RD, 16'h07C0, "R1"); chk(S_PWR, 0, "R1"); chk(S_LINK, 0, "R1");
        chk(S_LOCKS, 0, "R1"); chk(S_PLED, 0, "R1"); chk(S_ALED, 0, "R1");

        wr(16'hFFFF);
        chk(S_RD, 16'h17C0, "R2"); chk(S_LOCKP, 1, "R3"); chk(S_LINK, 1, "R6");
        chk(S_EVT, 1, "R11"); chk(S_LOCKS, 0, "R4"); chk(S_PWR, 0, "R5");
        idle(1);
        chk(S_LOCKP, 0, "R3"); chk(S_LOCKS, 1, "R4"); chk(S_EVT, 0, "R11");

        wr(16'h0140);
        chk(S_RD, 16'h0140, "R5"); chk(S_PWR, 1, "R5"); chk(S_PLED, 1, "R8");
        chk(S_ALED, 1, "R8"); chk(S_LOCKP, 0, "R3"); chk(S_LINK, 0, "R6");
        idle(1);
        chk(S_LOCKS, 1, "R3");

        wr(16'h0000);
        chk(S_RD, 16'h0000, "R10"); chk(S_PLED, 1, "R10"); chk(S_ALED, 1, "R10");
        wr(16'h03C0);
        chk(S_PLED, 0, "R8"); chk(S_ALED, 0, "R8");
        wr(16'h0000);
        chk(S_PLED, 0, "R10"); chk(S_ALED, 0, "R10"); chk(S_RD, 16'h0000, "R10");

        wr(16'h1180);
        chk(S_RD, 16'h1180, "R6"); chk(S_PLED, 1, "R8");
        warm_wr(16'h0400);
        chk(S_RD, 16'h13C0, "R7"); chk(S_PWR, 1, "R7"); chk(S_LINK, 1, "R7");
        chk(S_EVT, 0, "R7"); chk(S_PLED, 0, "R7"); chk(S_ALED, 0, "R7");
        chk(S_LOCKS, 1, "R4");

        wr(16'h1BC0);
        chk(S_LOCKP, 1, "R3"); chk(S_RD, 16'h13C0, "R3");
        idle(1);
        chk(S_LOCKS, 0, "R4");
        wr(16'h0800);
        idle(1);
        chk(S_LOCKS, 1, "R4");

        por();
        chk(S_RD, 16'h07C0, "R7"); chk(S_LINK, 0, "R7"); chk(S_PWR, 0, "R7");
        chk(S_LOCKS, 0, "R4");

        // k counts rising edges since the power-on reset release.
        wr(16'h0280);
        chk(S_PLED, 0, "R9"); chk(S_ALED, 0, "R9");
        for (int n = 0; n < 250; n++) begin
            int k;
            idle(1);
            k = 3 + n;
            chk(S_PLED, 16'((k / HALF) % 2), "R9");
            chk(S_ALED, 16'((k / HALF) % 2), "R9");
        end

        idle(3);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule